// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Split HI/LO Accumulator

This execution unit sits beside the integer pipeline of a 64-bit core and runs multiply and multiply-accumulate operations. It takes two 32-bit operands, a 5-bit variant code and a 6-bit function code. It keeps a 64-bit accumulator. The upper word of the accumulator appears, sign-extended, as the 64-bit HI register. The lower word appears, sign-extended, as the 64-bit LO register. Depending on the codes, the unit forms a signed or unsigned 64-bit product. It then replaces the accumulator with the product or with the negated product, adds the product to the accumulator, or subtracts the product from it.

Each operation can return one accumulator half as a 64-bit destination value, sign-extended from 32 bits. The half is chosen by the code. One code updates the accumulator and writes no destination. A saturation enable clamps accumulate-add results. A start is accepted only when the unit is idle. The result is registered and flagged by a one-cycle valid pulse on the following cycle. Codes the unit does not recognise leave the accumulator untouched and raise an illegal-operation flag.

Top module: `hilo_mac`

## Requirements
- R1: While `rst_n` is low, and after its release, the accumulator reads zero, so `hi_q` and `lo_q` are zero, and `res_valid`, `res_wr`, `illegal` and `res_data` are zero.
- R2: `hi_q` is accumulator bits 63:32 sign-extended to 64 bits, and `lo_q` is accumulator bits 31:0 sign-extended to 64 bits.
- R3: With `func`=6'b101000, the variant codes 5'b00000, 5'b00010 and 5'b01010 add the signed product to the accumulator, and 5'b00011 and 5'b01011 add the unsigned product. Variant 5'b00000 gives `res_wr`=0.
- R4: With `func`=6'b101000, the variant codes 5'b00100, 5'b00101, 5'b01100 and 5'b01101 replace the accumulator with the product. The codes 5'b00100 and 5'b01100 use the signed product, and 5'b00101 and 5'b01101 use the unsigned product.
- R5: With `func`=6'b011000 (signed) or 6'b011001 (unsigned), variants 5'b00011 and 5'b01011 set the accumulator to minus the product, and 5'b01111 subtracts the product from it. Variant 5'b00111 subtracts the product only with `func`=6'b011001.
- R6: A signed product takes both operands as 32-bit two's complement values. An unsigned product takes both as 32-bit unsigned values. Both produce a full 64-bit result.
- R7: `res_data` is the new accumulator's low half when variant bit 3 is 0, and its high half when variant bit 3 is 1, in each case sign-extended to 64 bits. `res_wr` is 1 for every legal code except the no-write accumulate.
- R8: With `sat_en`=1, a signed accumulate-add whose exact sum is above 0x7FFFFFFF yields 0x000000007FFFFFFF. One whose exact sum is below -2^31 yields 0xFFFFFFFF80000000.
- R9: With `sat_en`=1, an unsigned accumulate-add whose exact sum, taken as unsigned, is above 0x7FFFFFFF yields all ones.
- R10: When `start` is sampled high with `res_valid` low, `res_valid` is high for exactly the next cycle. A `start` sampled while `res_valid` is high is ignored.
- R11: Any code not listed in R3 to R5 raises `illegal` with `res_wr`=0, `res_data`=0 for that result, and leaves the accumulator unchanged.
- R12: `sat_en` has no effect on the replace, negate and subtract operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run one operation |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| variant | input | 5 | Variant code |
| func | input | 6 | Function code |
| sat_en | input | 1 | Saturate accumulate-add results |
| res_valid | output | 1 | One-cycle result strobe |
| res_wr | output | 1 | Destination value should be written |
| res_data | output | 64 | Sign-extended destination value |
| illegal | output | 1 | Unrecognised code for this result |
| hi_q | output | 64 | HI register view of the accumulator |
| hi_q | output | 64 | HI register view of the accumulator |
| lo_q | output | 64 | LO register view of the accumulator |

## Verification
The assertions assume that `start` and the operation fields are stable around the sampling edge. They also assume a caller may raise `start` again while a result is being strobed, so the one-cycle valid property treats such a start as ignored rather than as an error. The bench drives every field at the falling edge and holds it through the next rising edge. It deliberately keeps `start` high into the valid cycle once, to show that the second request is dropped. The saturation bound properties hold only for accumulate-add codes with `sat_en` high, and the stimulus takes the accumulator to both clamp limits from large prior values.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;
  localparam int VAR_W = 5;
  localparam int FN_W  = 6;

  typedef enum logic [1:0] {
    ACC_ADD = 2'd0,
    ACC_SUB = 2'd1,
    ACC_SET = 2'd2,
    ACC_NEG = 2'd3
  } acc_op_e;

  typedef struct packed {
    logic    legal;
    acc_op_e op;
    logic    usgn;
    logic    hi_sel;
    logic    wr;
  } mac_dec_t;
endpackage

// File: rtl/hilo_mac_decode.sv
module hilo_mac_decode
  import hilo_mac_pkg::*;
(
  input  logic [VAR_W-1:0] variant,
  input  logic [FN_W-1:0]  func,
  output mac_dec_t         dec
);
  localparam logic [FN_W-1:0] FN_ADDFAM = 6'b101000;
  localparam logic [FN_W-1:0] FN_NEG_S  = 6'b011000;
  localparam logic [FN_W-1:0] FN_NEG_U  = 6'b011001;

  always_comb begin
    dec        = '0;
    dec.op     = ACC_ADD;
    dec.hi_sel = variant[3];
    dec.wr     = 1'b1;
    if (func == FN_ADDFAM) begin
      unique case (variant)
        5'b00000: begin dec.legal = 1'b1; dec.wr = 1'b0; end
        5'b00010, 5'b01010: dec.legal = 1'b1;
        5'b00011, 5'b01011: begin dec.legal = 1'b1; dec.usgn = 1'b1; end
        5'b00100, 5'b01100: begin dec.legal = 1'b1; dec.op = ACC_SET; end
        5'b00101, 5'b01101: begin
          dec.legal = 1'b1; dec.op = ACC_SET; dec.usgn = 1'b1;
        end
        default: dec.legal = 1'b0;
      endcase
    end else if (func == FN_NEG_S || func == FN_NEG_U) begin
      dec.usgn = func[0];
      unique case (variant)
        5'b00011, 5'b01011: begin dec.legal = 1'b1; dec.op = ACC_NEG; end
        5'b01111:           begin dec.legal = 1'b1; dec.op = ACC_SUB; end
        5'b00111: begin dec.legal = func[0]; dec.op = ACC_SUB; end
        default:  dec.legal = 1'b0;
      endcase
    end
    if (!dec.legal) begin
      dec.wr = 1'b0;
    end
  end
endmodule

// File: rtl/hilo_mac_mul.sv
module hilo_mac_mul #(
  parameter int OPW = 32
) (
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  input  logic             usgn,
  output logic [2*OPW-1:0] prod
);
  localparam int EW = OPW + 1;

  logic signed [EW-1:0]   ea;
  logic signed [EW-1:0]   eb;
  logic signed [2*EW-1:0] full;

  always_comb begin
    ea   = {(~usgn & a[OPW-1]), a};
    eb   = {(~usgn & b[OPW-1]), b};
    full = ea * eb;
    prod = full[2*OPW-1:0];
  end
endmodule

// File: rtl/hilo_mac_accum.sv
module hilo_mac_accum
  import hilo_mac_pkg::*;
#(
  parameter int OPW = 32
) (
  input  logic [2*OPW-1:0] acc_i,
  input  logic [2*OPW-1:0] prod_i,
  input  acc_op_e          op,
  input  logic             usgn,
  input  logic             sat_en,
  output logic [2*OPW-1:0] acc_o
);
  localparam int ACCW = 2 * OPW;
  localparam logic [ACCW:0] LIM_HI = {{(ACCW-OPW+2){1'b0}}, {(OPW-1){1'b1}}};
  localparam logic [ACCW:0] LIM_LO = {{(ACCW-OPW+2){1'b1}}, {(OPW-1){1'b0}}};

  logic [ACCW:0] sum_s;
  logic [ACCW:0] sum_u;
  logic [ACCW-1:0] add_res;

  always_comb begin
    sum_s = {acc_i[ACCW-1], acc_i} + {prod_i[ACCW-1], prod_i};
    sum_u = {1'b0, acc_i} + {1'b0, prod_i};
    add_res = acc_i + prod_i;
    if (sat_en) begin
      if (usgn) begin
        if (sum_u > LIM_HI) add_res = '1;
      end else begin
        if ($signed(sum_s) > $signed(LIM_HI))      add_res = LIM_HI[ACCW-1:0];
        else if ($signed(sum_s) < $signed(LIM_LO)) add_res = LIM_LO[ACCW-1:0];
      end
    end
    unique case (op)
      ACC_ADD: acc_o = add_res;
      ACC_SUB: acc_o = acc_i - prod_i;
      ACC_SET: acc_o = prod_i;
      default: acc_o = '0 - prod_i;
    endcase
  end
endmodule

// File: rtl/hilo_mac.sv
module hilo_mac
  import hilo_mac_pkg::*;
#(
  parameter int OPW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [OPW-1:0]       op_a,
  input  logic [OPW-1:0]       op_b,
  input  logic [VAR_W-1:0]     variant,
  input  logic [FN_W-1:0]      func,
  input  logic                 sat_en,
  output logic                 res_valid,
  output logic                 res_wr,
  output logic [2*OPW-1:0]     res_data,
  output logic                 illegal,
  output logic [2*OPW-1:0]     hi_q,
  output logic [2*OPW-1:0]     lo_q
);
  localparam int ACCW = 2 * OPW;

  mac_dec_t        dec;
  logic [ACCW-1:0] prod;
  logic [ACCW-1:0] acc_new;
  logic [ACCW-1:0] acc_q, acc_d;
  logic            accept;
  logic            acc_en;
  logic            valid_d, wr_d, ill_d;
  logic [ACCW-1:0] data_d;
  logic [OPW-1:0]  half_sel;

  hilo_mac_decode u_dec (.variant(variant), .func(func), .dec(dec));

  hilo_mac_mul #(.OPW(OPW)) u_mul (
    .a(op_a), .b(op_b), .usgn(dec.usgn), .prod(prod)
  );

  hilo_mac_accum #(.OPW(OPW)) u_acc (
    .acc_i(acc_q), .prod_i(prod), .op(dec.op), .usgn(dec.usgn),
    .sat_en(sat_en), .acc_o(acc_new)
  );

  always_comb begin
    accept   = start && !res_valid;
    acc_en   = accept && dec.legal;
    acc_d    = acc_new;
    valid_d  = accept;
    half_sel = dec.hi_sel ? acc_new[ACCW-1:OPW] : acc_new[OPW-1:0];
    wr_d     = accept && dec.wr;
    ill_d    = accept && !dec.legal;
    data_d   = dec.legal ? {{OPW{half_sel[OPW-1]}}, half_sel} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_wr    <= 1'b0;
      illegal   <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= valid_d;
      res_wr    <= wr_d;
      illegal   <= ill_d;
      if (accept) begin
        res_data <= data_d;
      end
    end
  end

  assign hi_q = {{OPW{acc_q[ACCW-1]}}, acc_q[ACCW-1:OPW]};
  assign lo_q = {{OPW{acc_q[OPW-1]}}, acc_q[OPW-1:0]};

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R10
  AST_START_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !res_valid) |=> res_valid); // R10
  AST_ILLEGAL_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !res_valid && !dec.legal) |=> (illegal && $stable(acc_q))); // R11
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !res_wr); // R11
  AST_SAT_SIGNED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.legal && dec.op == ACC_ADD && !dec.usgn && sat_en)
    |=> ($signed(acc_q) <= $signed({{(OPW+1){1'b0}}, {(OPW-1){1'b1}}})
         && $signed(acc_q) >= $signed({{(OPW+1){1'b1}}, {(OPW-1){1'b0}}}))); // R8
  AST_SAT_UNSIGNED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.legal && dec.op == ACC_ADD && dec.usgn && sat_en)
    |=> (acc_q <= {{(OPW+1){1'b0}}, {(OPW-1){1'b1}}} || acc_q == '1)); // R9
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accept) |-> !res_valid); // R10
endmodule

// File: tb/hilo_mac_test.sv
module hilo_mac_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [4:0]  variant = '0;
  logic [5:0]  func = '0;
  logic        sat_en = 1'b0;
  logic        res_valid, res_wr, illegal;
  logic [63:0] res_data, hi_q, lo_q;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hilo_mac uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .variant(variant), .func(func), .sat_en(sat_en), .res_valid(res_valid),
    .res_wr(res_wr), .res_data(res_data), .illegal(illegal),
    .hi_q(hi_q), .lo_q(lo_q)
  );

  typedef struct packed {
    logic [4:0]  v;
    logic [5:0]  f;
    logic [31:0] a;
    logic [31:0] b;
    logic        sat;
    logic        ewr;
    logic        eill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [0:NV-1] = '{
    '{5'b00100, 6'b101000, 32'd7,        32'hFFFFFFFD, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 signed set, low
    '{5'b01100, 6'b101000, 32'hFFFFFFFE, 32'd3,        1'b0, 1'b1, 1'b0, 4'd4},  // R4 signed set, high
    '{5'b00101, 6'b101000, 32'hFFFFFFFF, 32'd2,        1'b0, 1'b1, 1'b0, 4'd6},  // R6 unsigned set, low
    '{5'b01101, 6'b101000, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b0, 4'd7},  // R7 unsigned set, high
    '{5'b00000, 6'b101000, 32'd3,        32'd4,        1'b0, 1'b0, 1'b0, 4'd3},  // R3 no-write accumulate
    '{5'b00010, 6'b101000, 32'hFFFFFFFF, 32'd5,        1'b0, 1'b1, 1'b0, 4'd3},  // R3 signed acc, low
    '{5'b00011, 6'b101000, 32'h80000000, 32'd2,        1'b0, 1'b1, 1'b0, 4'd3},  // R3 unsigned acc, low
    '{5'b01010, 6'b101000, 32'd100,      32'hFFFFFF9C, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 signed acc, high
    '{5'b01011, 6'b101000, 32'h90000000, 32'h10,       1'b0, 1'b1, 1'b0, 4'd3},  // R3 unsigned acc, high
    '{5'b00011, 6'b011000, 32'd5,        32'd6,        1'b0, 1'b1, 1'b0, 4'd5},  // R5 negate signed, low
    '{5'b01011, 6'b011001, 32'hFFFFFFFF, 32'd1,        1'b0, 1'b1, 1'b0, 4'd5},  // R5 negate unsigned, high
    '{5'b01111, 6'b011000, 32'hFFFFFFF0, 32'h100,      1'b0, 1'b1, 1'b0, 4'd5},  // R5 subtract signed, high
    '{5'b00111, 6'b011001, 32'hFFFFFFFF, 32'h3,        1'b0, 1'b1, 1'b0, 4'd5},  // R5 subtract unsigned, low
    '{5'b00111, 6'b011000, 32'd9,        32'd9,        1'b0, 1'b0, 1'b1, 4'd11}, // R11 signed form not legal
    '{5'b00001, 6'b101000, 32'd9,        32'd9,        1'b0, 1'b0, 1'b1, 4'd11}, // R11 unknown variant
    '{5'b00010, 6'b000000, 32'd9,        32'd9,        1'b0, 1'b0, 1'b1, 4'd11}, // R11 unknown function
    '{5'b00100, 6'b101000, 32'h40000000, 32'd4,        1'b1, 1'b1, 1'b0, 4'd12}, // R12 set not clamped
    '{5'b00010, 6'b101000, 32'h7FFFFFFF, 32'd1,        1'b1, 1'b1, 1'b0, 4'd8},  // R8 clamp high
    '{5'b00010, 6'b101000, 32'hFFFF0000, 32'h00010000, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 clamp low
    '{5'b00011, 6'b101000, 32'd1,        32'd1,        1'b1, 1'b1, 1'b0, 4'd9},  // R9 unsigned clamp
    '{5'b01010, 6'b101000, 32'd0,        32'd0,        1'b1, 1'b1, 1'b0, 4'd8},  // R8 in range, unchanged
    '{5'b01011, 6'b011000, 32'h10000,    32'h10000,    1'b1, 1'b1, 1'b0, 4'd12}  // R12 negate not clamped
  };

  logic [63:0] m_acc;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  // Reference model written from the requirements
  task automatic model(input vec_t t, output logic [63:0] data);
    logic [63:0] p, nacc;
    logic        u, hi;
    logic signed [64:0] ss;
    logic [64:0] su;
    u  = (t.f == 6'b101000) ? (t.v == 5'b00011 || t.v == 5'b01011 ||
                               t.v == 5'b00101 || t.v == 5'b01101) : t.f[0];
    hi = t.v[3];
    p  = u ? {32'd0, t.a} * {32'd0, t.b} : sx(t.a) * sx(t.b);
    nacc = m_acc;
    if (t.eill) begin
      data = 64'd0;
      return;
    end
    if (t.f == 6'b101000 && (t.v == 5'b00100 || t.v == 5'b00101 ||
                             t.v == 5'b01100 || t.v == 5'b01101)) nacc = p;
    else if (t.f != 6'b101000 && (t.v == 5'b00011 || t.v == 5'b01011)) nacc = -p;
    else if (t.f != 6'b101000) nacc = m_acc - p;
    else begin
      nacc = m_acc + p;
      if (t.sat && !u) begin
        ss = $signed({m_acc[63], m_acc}) + $signed({p[63], p});
        if (ss > 65'sh7FFFFFFF) nacc = 64'h7FFFFFFF;
        else if (ss < -65'sh80000000) nacc = 64'hFFFFFFFF80000000;
      end else if (t.sat && u) begin
        su = {1'b0, m_acc} + {1'b0, p};
        if (su > 65'h7FFFFFFF) nacc = '1;
      end
    end
    m_acc = nacc;
    data  = hi ? sx(nacc[63:32]) : sx(nacc[31:0]);
  endtask

  task automatic issue(input vec_t t);
    @(negedge clk);
    op_a = t.a; op_b = t.b; variant = t.v; func = t.f; sat_en = t.sat;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] exp_d;
    string tag;
    m_acc = '0;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", {63'd0, res_valid}, 64'd0);
    chk("R1", "hi in reset", hi_q, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "lo after reset", lo_q, 64'd0);
    chk("R1", "data after reset", res_data, 64'd0);

    for (int i = 0; i < NV; i++) begin
      tag = $sformatf("R%0d", VECS[i].req);
      model(VECS[i], exp_d);
      issue(VECS[i]);
      chk("R10", "valid", {63'd0, res_valid}, 64'd1);
      chk(tag, "res_wr", {63'd0, res_wr}, {63'd0, VECS[i].ewr});
      chk(tag, "illegal", {63'd0, illegal}, {63'd0, VECS[i].eill});
      chk(tag, "res_data", res_data, exp_d);
      chk("R2", "hi_q", hi_q, sx(m_acc[63:32]));
      chk("R2", "lo_q", lo_q, sx(m_acc[31:0]));
    end

    // R10: start held into the valid cycle is dropped
    @(negedge clk);
    op_a = 32'd2; op_b = 32'd3; variant = 5'b00100; func = 6'b101000; sat_en = 1'b0;
    start = 1'b1;
    @(negedge clk);
    m_acc = 64'd6;
    chk("R10", "first valid", {63'd0, res_valid}, 64'd1);
    op_a = 32'd50; op_b = 32'd50;
    @(negedge clk);
    start = 1'b0;
    chk("R10", "second start ignored", {63'd0, res_valid}, 64'd0);
    chk("R10", "acc kept", lo_q, 64'd6);
    @(negedge clk);
    chk("R10", "still idle", {63'd0, res_valid}, 64'd0);

    // R1: reset mid-run clears the accumulator
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "acc cleared", lo_q, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid idle", {63'd0, res_valid}, 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule